// File: doc/BRIEF.md
# Virtual Processor Run/Stop Controller

This block starts and halts a group of virtual processors (VPs) on command from software. A 64-bit register port carries three registers: a run command, a stop command and a status register that returns which VPs are running. A run command brings up every selected VP that is idle and gives it a one-cycle reset pulse. A stop command takes down every selected VP that is running and gives it a one-cycle halt request. VPs whose state would not change are left alone.

The same three registers appear in two address windows, one for the cluster and one for the core, and the two behave the same way. The number of VPs and the set of VPs that come up running after a controller reset are parameters. A start-up mask that names a VP beyond the configured count stops elaboration.

Top module: `vp_runctl`

## Requirements
- R1: Only the low NUM_VP bits of a written command word select VPs. Bits at or above NUM_VP are discarded.
- R2: A write to the run register (offset 0x8 in a window) sets the running bit of each selected idle VP. It pulses `vp_reset` for that VP in the cycle after the write edge.
- R3: A run write that selects a VP that is already running changes neither its running bit nor its `vp_reset` line.
- R4: A write to the stop register (offset 0x0 in a window) clears the running bit of each selected running VP. It pulses `vp_halt` for that VP in the cycle after the write edge.
- R5: A stop write that selects an idle VP has no effect on that VP's state or its `vp_halt` line.
- R6: A read of the status register (offset 0x10 in a window) returns the running vector, zero-extended to 64 bits, on `rdata` one cycle after the read request.
- R7: The registers answer the same way at window base 0x2000 and at window base 0x4000.
- R8: A write to any other address has no effect. A read of any other address returns zero.
- R9: During reset the running vector is zero and no pulse is driven. In the first cycle after reset is released, `vp_reset` shows the START_RUNNING VPs, and the running vector holds them from then on.
- R10: Every `vp_reset` and `vp_halt` pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| addr | input | ADDR_W | Register byte address |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 64 | Write data (VP bitmask) |
| rdata | output | 64 | Read data, valid the cycle after `rd_en` |
| vp_reset | output | NUM_VP | One-cycle reset pulse for each VP that starts |
| vp_halt | output | NUM_VP | One-cycle halt request for each VP that stops |

## Verification
The assertions assume that `wr_en` and `rd_en` are single-cycle strobes that share one address, so a write and a read never target different registers in the same cycle. They also assume the two windows never overlap. The pulse properties compare each pulse with the running state one cycle earlier, so they depend on reset being held from time zero. The stimulus drives one access at a time on the falling edge. Each write is followed by two idle cycles and a status read before the next access, so every pulse and readback is observed on its own.

// File: rtl/vp_runctl_pkg.sv
package vp_runctl_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STOP = 2'd1,
    SEL_RUN  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  // valid-VP mask for a given VP count (1..64)
  function automatic logic [63:0] vp_mask64(input int unsigned n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  // exact register address match
  function automatic logic reg_hit(input logic [31:0] a, input logic [31:0] base,
                                   input logic [31:0] ofs);
    return a == (base + ofs);
  endfunction

endpackage

// File: rtl/vp_runctl_decode.sv
module vp_runctl_decode
  import vp_runctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BASE_CL  = 32'h2000,
  parameter int unsigned BASE_CO  = 32'h4000,
  parameter int unsigned OFS_STOP = 32'h0,
  parameter int unsigned OFS_RUN  = 32'h8,
  parameter int unsigned OFS_STAT = 32'h10
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [1:0]        win_hit
);
  localparam int unsigned NWIN = 2;
  localparam logic [31:0] BASES [NWIN] = '{BASE_CL, BASE_CO};

  logic [NWIN-1:0] hit_stop, hit_run, hit_stat;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit_stop[w] = reg_hit(32'(addr), BASES[w], OFS_STOP);
    assign hit_run[w]  = reg_hit(32'(addr), BASES[w], OFS_RUN);
    assign hit_stat[w] = reg_hit(32'(addr), BASES[w], OFS_STAT);
    assign win_hit[w]  = hit_stop[w] | hit_run[w] | hit_stat[w];
  end

  always_comb begin
    sel = SEL_NONE;
    if (|hit_stop)      sel = SEL_STOP;
    else if (|hit_run)  sel = SEL_RUN;
    else if (|hit_stat) sel = SEL_STAT;
  end
endmodule

// File: rtl/vp_runctl_core.sv
module vp_runctl_core #(
  parameter int unsigned NUM_VP        = 1,
  parameter logic [63:0] START_RUNNING = 64'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VP-1:0] start_cmd,
  input  logic [NUM_VP-1:0] stop_cmd,
  output logic [NUM_VP-1:0] running_o,
  output logic [NUM_VP-1:0] vp_reset_o,
  output logic [NUM_VP-1:0] vp_halt_o
);
  localparam logic [NUM_VP-1:0] START_V = NUM_VP'(START_RUNNING);

  logic              boot_q;
  logic [NUM_VP-1:0] run_q, rst_q, hlt_q;
  logic [NUM_VP-1:0] start_all, start_ev, stop_ev, run_d;

  assign start_all = start_cmd | (boot_q ? START_V : '0);

  // per-VP events: a start only for an idle VP, a stop only for a running VP
  for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
    assign start_ev[i] = start_all[i] & ~run_q[i];
    assign stop_ev[i]  = stop_cmd[i]  &  run_q[i];
    assign run_d[i]    = (run_q[i] | start_ev[i]) & ~stop_ev[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      run_q  <= '0;
      rst_q  <= '0;
      hlt_q  <= '0;
    end else begin
      boot_q <= 1'b0;
      run_q  <= run_d;
      rst_q  <= start_ev;
      hlt_q  <= stop_ev;
    end
  end

  assign running_o  = run_q;
  assign vp_reset_o = rst_q;
  assign vp_halt_o  = hlt_q;

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_reset_o & $past(run_q)) == '0);                                  // R3
  AST_STOP_FROM_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_halt_o & ~$past(run_q)) == '0);                                  // R5
  AST_STATE_CHANGE_PULSED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q ^ $past(run_q)) == (vp_reset_o | vp_halt_o));                 // R2
  AST_RESET_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_reset_o & $past(vp_reset_o)) == '0);                             // R10
  AST_HALT_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_halt_o & $past(vp_halt_o)) == '0);                               // R10
  AST_NO_RESET_AND_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_reset_o & vp_halt_o) == '0);                                     // R4
  AST_BOOT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |=> (vp_reset_o & START_V) == START_V);                       // R9
endmodule

// File: rtl/vp_runctl_readback.sv
module vp_runctl_readback
  import vp_runctl_pkg::*;
#(
  parameter int unsigned NUM_VP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [NUM_VP-1:0] running,
  output logic [63:0]       rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= (sel == SEL_STAT) ? 64'(running) : 64'd0;
  end
endmodule

// File: rtl/vp_runctl.sv
module vp_runctl
  import vp_runctl_pkg::*;
#(
  parameter int unsigned NUM_VP        = 1,
  parameter logic [63:0] START_RUNNING = 64'h1,
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned BASE_CL       = 32'h2000,
  parameter int unsigned BASE_CO       = 32'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  output logic [NUM_VP-1:0] vp_reset,
  output logic [NUM_VP-1:0] vp_halt
);
  localparam logic [63:0] VP_MASK = vp_mask64(NUM_VP);

  if (NUM_VP < 1 || NUM_VP > 64) begin : g_bad_count
    $error("NUM_VP must lie in 1..64");
  end
  if ((START_RUNNING & ~VP_MASK) != 64'd0) begin : g_bad_start
    $error("START_RUNNING names a VP beyond NUM_VP");
  end

  reg_sel_e          sel;
  logic [1:0]        win_hit;
  logic [NUM_VP-1:0] cmd_bits, start_cmd, stop_cmd, running;

  vp_runctl_decode #(
    .ADDR_W (ADDR_W),
    .BASE_CL(BASE_CL),
    .BASE_CO(BASE_CO)
  ) u_dec (
    .addr   (addr),
    .sel    (sel),
    .win_hit(win_hit)
  );

  assign cmd_bits  = NUM_VP'(wdata & VP_MASK);
  assign start_cmd = (wr_en && sel == SEL_RUN)  ? cmd_bits : '0;
  assign stop_cmd  = (wr_en && sel == SEL_STOP) ? cmd_bits : '0;

  vp_runctl_core #(
    .NUM_VP       (NUM_VP),
    .START_RUNNING(START_RUNNING)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd),
    .running_o (running),
    .vp_reset_o(vp_reset),
    .vp_halt_o (vp_halt)
  );

  vp_runctl_readback #(.NUM_VP(NUM_VP)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .sel    (sel),
    .running(running),
    .rdata  (rdata)
  );

  AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_hit));                                                  // R7
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_STAT) |=> rdata == 64'($past(running)));       // R6
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |=> rdata == 64'd0);                      // R8
  AST_UNMAPPED_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE) |=> (vp_reset | vp_halt) == '0);          // R8
endmodule

// File: tb/vp_runctl_test.sv
`timescale 1ns/1ps
module vp_runctl_test;
  localparam int unsigned NV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   addr = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic [NV-1:0] vp_reset, vp_halt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vp_runctl #(.NUM_VP(NV), .START_RUNNING(64'h5)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .vp_reset(vp_reset), .vp_halt(vp_halt)
  );

  typedef struct packed {
    logic [15:0]   a;
    logic [63:0]   d;
    logic [NV-1:0] rst;
    logic [NV-1:0] hlt;
    logic [NV-1:0] run;
  } vec_t;

  // running vector is 0101 when the table starts
  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{16'h2008, 64'hF2,               4'b0010, 4'b0000, 4'b0111}, // R1 R2
    '{16'h2008, 64'h5,                4'b0000, 4'b0000, 4'b0111}, // R3
    '{16'h2000, 64'h9,                4'b0000, 4'b0001, 4'b0110}, // R4 R5
    '{16'h4000, 64'h8,                4'b0000, 4'b0000, 4'b0110}, // R5 R7
    '{16'h4008, 64'hF,                4'b1001, 4'b0000, 4'b1111}, // R2 R7
    '{16'h2018, 64'hF,                4'b0000, 4'b0000, 4'b1111}, // R8
    '{16'h2010, 64'h0,                4'b0000, 4'b0000, 4'b1111}, // R8
    '{16'h4000, 64'hFFFF_FFFF_FFFF_FFF0, 4'b0000, 4'b0000, 4'b1111}, // R1
    '{16'h2000, 64'hF,                4'b0000, 4'b1111, 4'b0000}, // R4
    '{16'h0008, 64'hF,                4'b0000, 4'b0000, 4'b0000}, // R8
    '{16'h4008, 64'h6,                4'b0110, 4'b0000, 4'b0110}  // R2 R7
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    chk("R9 reset rdata", rdata, 64'd0);
    chk("R9 reset pulses", {60'd0, vp_reset | vp_halt}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 boot vp_reset", {60'd0, vp_reset}, 64'h5);
    chk("R9 boot vp_halt", {60'd0, vp_halt}, 64'h0);
    @(negedge clk);
    chk("R10 boot pulse width", {60'd0, vp_reset}, 64'h0);
    do_read(16'h2010, rd);
    chk("R9 R6 boot running", rd, 64'h5);

    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i].a, VEC[i].d);
      chk($sformatf("vec%0d vp_reset", i), {60'd0, vp_reset}, {60'd0, VEC[i].rst});
      chk($sformatf("vec%0d vp_halt", i), {60'd0, vp_halt}, {60'd0, VEC[i].hlt});
      @(negedge clk);
      chk($sformatf("R10 vec%0d pulses end", i), {60'd0, vp_reset | vp_halt}, 64'd0);
      do_read((i % 2 == 0) ? 16'h2010 : 16'h4010, rd);
      chk($sformatf("R6 R7 vec%0d running", i), rd, {60'd0, VEC[i].run});
    end

    do_read(16'h2018, rd);
    chk("R8 unmapped read", rd, 64'd0);
    do_read(16'h3010, rd);
    chk("R8 read outside windows", rd, 64'd0);
    do_read(16'h4010, rd);
    chk("R7 status in core window", rd, 64'h6);

    // controller reset while VPs run: state cleared, start-up set comes back
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 mid reset pulses", {60'd0, vp_reset | vp_halt}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reboot vp_reset", {60'd0, vp_reset}, 64'h5);
    do_read(16'h2010, rd);
    chk("R9 reboot running", rd, 64'h5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule